// File: doc/BRIEF.md
# Traffic-Class Priority Read Arbiter

This block picks one memory read request per cycle from a set of requesting ports. Each port raises a request valid together with a two-bit traffic-class tag. The arbiter answers with a per-port ready, which is the grant. A request is taken in the cycle where its valid and ready are both high. Low-latency reads normally win, plain video reads come next and best-effort reads come last. Ties inside a class are settled by a round-robin pointer.

Video reads tolerate long waits, but the wait has to stay bounded. Each port therefore keeps an age counter for its pending video request and has its own programmable latency limit. Once a video request has waited as long as its port's limit, it counts as expired and beats even low-latency traffic. Among several expired requests, the oldest wins.

Back-pressure rules: a requester holds valid and its class tag stable until it sees ready. Ready is computed combinationally from the current valids, tags, ages and round-robin pointer. It is never asserted to a port whose valid is low. If a requester drops valid before it is granted, its video age is discarded. A requester that keeps valid high after a grant presents a new request, and that new request starts with age zero.

Top module: `qos_read_arbiter`

## Requirements
- R1: Class tag encoding per port is 2'b00 best effort, 2'b01 video, 2'b10 low latency. The code 2'b11 is handled exactly like best effort.
- R2: `req_ready` has at most one bit set, and only at a port whose `req_valid` is high. Whenever any `req_valid` bit is high, exactly one ready bit is set in that same cycle.
- R3: With no expired video request present, low-latency requests are granted before video requests, and video requests before best-effort requests.
- R4: A port's video age starts at zero. It rises by one on each clock edge at which that port holds a video request that is not granted, and it saturates at all ones. It returns to zero on a grant, or when the port does not hold a video request.
- R5: A video request is expired when its age is greater than or equal to its port's `vid_limit` field, which is bits [p*AGE_W +: AGE_W]. Any expired request is granted ahead of low-latency and all other traffic.
- R6: Among expired video requests, the one with the largest age wins. Equal ages go to the lowest port index.
- R7: Within the class selected by R3, the search starts at the port after the last granted port and wraps around. One pointer is shared by all classes and is updated on every grant. After reset the pointer is at the last port, so port 0 is searched first.
- R8: A `vid_limit` of zero makes a pending video request expired in its first cycle, so it beats a simultaneous low-latency request.
- R9: `gnt_valid` is high exactly when a ready bit is set, and `gnt_port` then holds that bit's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_PORTS | Per-port read request valid |
| req_class | input | 2*NUM_PORTS | Per-port class tag, port p at bits [2p+1:2p] |
| vid_limit | input | NUM_PORTS*AGE_W | Per-port video latency limit in cycles |
| req_ready | output | NUM_PORTS | One-hot grant, request taken when valid and ready are high |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_port | output | IDX_W | Index of the granted port |

## Verification
The bench runs with four ports and four-bit ages. It first sweeps every combination of valid mask and class tags against large limits, so each cycle shows whether class order and the rotating pointer are respected with little interference from expiry. A second sweep holds pseudo-random patterns for several cycles under limits between zero and three. This lets ages build up and separates the oldest-expired choice from round-robin choice. Directed sequences cover the spare class code, a video request starved by a low-latency hog until it reaches its limit, and the immediate expiry that a zero limit causes.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  typedef enum logic [1:0] {
    TC_BEST   = 2'b00,
    TC_VIDEO  = 2'b01,
    TC_LOWLAT = 2'b10,
    TC_SPARE  = 2'b11
  } tclass_e;
endpackage

// File: rtl/qos_age_tracker.sv
module qos_age_tracker #(
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic             granted,
  input  logic [AGE_W-1:0] limit,
  output logic [AGE_W-1:0] age,
  output logic             expired
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 age <= '0;
    else if (!pending || granted) age <= '0;
    else if (age != AGE_MAX)    age <= age + 1'b1;
  end

  assign expired = pending && (age >= limit);
endmodule

// File: rtl/qos_rr_pick.sv
module qos_rr_pick #(
  parameter int NUM_PORTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_PORTS-1:0] mask,
  input  logic [IDX_W-1:0]     last,
  output logic [NUM_PORTS-1:0] pick
);
  always_comb begin
    int  idx;
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      idx = int'(last) + 1 + k;
      if (idx >= NUM_PORTS) idx = idx - NUM_PORTS;
      if (!found && mask[idx]) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/qos_oldest_pick.sv
module qos_oldest_pick #(
  parameter int NUM_PORTS = 4,
  parameter int AGE_W     = 8
) (
  input  logic [NUM_PORTS-1:0]       mask,
  input  logic [NUM_PORTS*AGE_W-1:0] ages,
  output logic [NUM_PORTS-1:0]       pick
);
  always_comb begin
    logic             found;
    logic [AGE_W-1:0] best;
    int               best_idx;
    found    = 1'b0;
    best     = '0;
    best_idx = 0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (mask[i] && (!found || ages[i*AGE_W +: AGE_W] > best)) begin
        found    = 1'b1;
        best     = ages[i*AGE_W +: AGE_W];
        best_idx = i;
      end
    end
    pick = '0;
    if (found) pick[best_idx] = 1'b1;
  end
endmodule

// File: rtl/qos_read_arbiter.sv
module qos_read_arbiter
  import qos_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int AGE_W     = 8,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       req_valid,
  input  logic [2*NUM_PORTS-1:0]     req_class,
  input  logic [NUM_PORTS*AGE_W-1:0] vid_limit,
  output logic [NUM_PORTS-1:0]       req_ready,
  output logic                       gnt_valid,
  output logic [IDX_W-1:0]           gnt_port
);
  logic [NUM_PORTS-1:0]       vid_mask, ll_mask, be_mask, exp_mask;
  logic [NUM_PORTS-1:0]       rr_mask, rr_pick, old_pick;
  logic [NUM_PORTS*AGE_W-1:0] age_q;
  logic [IDX_W-1:0]           last_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    tclass_e cls;
    assign cls         = tclass_e'(req_class[2*p +: 2]);
    assign vid_mask[p] = req_valid[p] && (cls == TC_VIDEO);
    assign ll_mask[p]  = req_valid[p] && (cls == TC_LOWLAT);
    assign be_mask[p]  = req_valid[p] && ((cls == TC_BEST) || (cls == TC_SPARE));

    qos_age_tracker #(.AGE_W(AGE_W)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (vid_mask[p]),
      .granted (req_ready[p]),
      .limit   (vid_limit[p*AGE_W +: AGE_W]),
      .age     (age_q[p*AGE_W +: AGE_W]),
      .expired (exp_mask[p])
    );
  end

  always_comb begin
    if (|ll_mask)       rr_mask = ll_mask;
    else if (|vid_mask) rr_mask = vid_mask;
    else                rr_mask = be_mask;
  end

  qos_rr_pick #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_rr (
    .mask (rr_mask),
    .last (last_q),
    .pick (rr_pick)
  );

  qos_oldest_pick #(.NUM_PORTS(NUM_PORTS), .AGE_W(AGE_W)) u_old (
    .mask (exp_mask),
    .ages (age_q),
    .pick (old_pick)
  );

  assign req_ready = (|exp_mask) ? old_pick : rr_pick;
  assign gnt_valid = |req_ready;

  always_comb begin
    gnt_port = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (req_ready[i]) gnt_port = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= IDX_W'(NUM_PORTS - 1);
    else if (gnt_valid) last_q <= gnt_port;
  end
endmodule

// File: rtl/qos_arb_checker.sv
module qos_arb_checker #(
  parameter int NUM_PORTS = 4,
  parameter int AGE_W     = 8,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_PORTS-1:0]       req_valid,
  input logic [2*NUM_PORTS-1:0]     req_class,
  input logic [NUM_PORTS*AGE_W-1:0] vid_limit,
  input logic [NUM_PORTS-1:0]       req_ready,
  input logic                       gnt_valid,
  input logic [IDX_W-1:0]           gnt_port,
  input logic [NUM_PORTS*AGE_W-1:0] age_flat
);
  logic [NUM_PORTS-1:0] hi_mask, ll_mask, age_zero;
  logic [1:0]           g_cls;
  logic [AGE_W-1:0]     g_age, g_lim;

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      hi_mask[i]  = req_valid[i] && (req_class[2*i +: 2] == 2'b01 || req_class[2*i +: 2] == 2'b10);
      ll_mask[i]  = req_valid[i] && (req_class[2*i +: 2] == 2'b10);
      age_zero[i] = (age_flat[i*AGE_W +: AGE_W] == '0);
    end
    g_cls = req_class[2*int'(gnt_port) +: 2];
    g_age = age_flat[AGE_W*int'(gnt_port) +: AGE_W];
    g_lim = vid_limit[AGE_W*int'(gnt_port) +: AGE_W];
  end

  p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  p_work_conserving_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |-> gnt_valid);

  p_port_matches_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req_ready[gnt_port]);

  p_best_effort_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && (g_cls == 2'b00 || g_cls == 2'b11)) |-> (hi_mask == '0));

  p_video_over_ll_only_when_expired_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && g_cls == 2'b01 && (|ll_mask)) |-> (g_age >= g_lim));

  p_age_clears_on_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> age_zero[$past(gnt_port)]);
endmodule

bind qos_read_arbiter qos_arb_checker #(.NUM_PORTS(NUM_PORTS), .AGE_W(AGE_W)) u_qos_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_class (req_class),
  .vid_limit (vid_limit),
  .req_ready (req_ready),
  .gnt_valid (gnt_valid),
  .gnt_port  (gnt_port),
  .age_flat  (age_q)
);

// File: tb/test_qos_read_arbiter.sv
`timescale 1ns/1ps
module test_qos_read_arbiter;
  localparam int N  = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_valid = '0;
  logic [2*N-1:0] req_class = '0;
  logic [N*AW-1:0] vid_limit = '1;
  logic [N-1:0]  req_ready;
  logic          gnt_valid;
  logic [1:0]    gnt_port;

  int checks = 0;
  int fails  = 0;
  int m_age[N];
  int m_last;

  always #5 clk = ~clk;

  qos_read_arbiter #(.NUM_PORTS(N), .AGE_W(AW)) i_qos_read_arbiter (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_class (req_class),
    .vid_limit (vid_limit), .req_ready (req_ready), .gnt_valid (gnt_valid),
    .gnt_port (gnt_port)
  );

  task automatic check_eq(input logic [7:0] got, input logic [7:0] exp, input string what, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // Drives one cycle, compares against the model, advances the model.
  task automatic run_cycle(input logic [3:0] v, input logic [7:0] c, input logic [15:0] lim, input string tag);
    int    cls[N];
    bit    vid[N];
    int    pick;
    int    want;
    string why;
    logic [3:0] exp_rdy;
    req_valid = v; req_class = c; vid_limit = lim;
    #1;
    pick = -1;
    why  = "R5/R6";
    for (int i = 0; i < N; i++) begin
      cls[i] = int'(c[2*i +: 2]);
      vid[i] = v[i] && cls[i] == 1;
      if (vid[i] && m_age[i] >= int'(lim[AW*i +: AW]))
        if (pick < 0 || m_age[i] > m_age[pick]) pick = i;
    end
    if (pick < 0) begin
      why  = "R3/R7";
      want = 0;
      for (int i = 0; i < N; i++) if (vid[i] && want == 0) want = 1;
      for (int i = 0; i < N; i++) if (v[i] && cls[i] == 2) want = 2;
      for (int k = 1; k <= N; k++) begin
        int idx;
        bit hit;
        idx = (m_last + k) % N;
        hit = v[idx] && ((want == 0) ? (cls[idx] == 0 || cls[idx] == 3) : (cls[idx] == want));
        if (pick < 0 && hit) pick = idx;
      end
    end
    exp_rdy = (pick >= 0) ? 4'(1 << pick) : 4'b0;
    if (tag != "") why = tag;
    check_eq(8'(req_ready), 8'(exp_rdy), "req_ready", why);
    check_eq({7'd0, gnt_valid}, {7'd0, pick >= 0}, "gnt_valid R9", why);
    if (pick >= 0) check_eq(8'(gnt_port), 8'(pick), "gnt_port R9", why);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (vid[i] && i != pick) m_age[i] = (m_age[i] < 15) ? m_age[i] + 1 : 15;
      else m_age[i] = 0;
    end
    if (pick >= 0) m_last = pick;
    @(negedge clk);
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [3:0]  pv;
    logic [7:0]  pc;
    logic [15:0] pl;
    for (int i = 0; i < N; i++) m_age[i] = 0;
    m_last = N - 1;
    repeat (3) @(negedge clk);
    #1;
    check_eq(8'(req_ready), 8'h0, "reset req_ready", "R2");
    check_eq({7'd0, gnt_valid}, 8'h0, "reset gnt_valid", "R9");
    rst_n = 1'b1;
    @(negedge clk);

    // R7: after reset port 0 is searched first among equal best-effort requests
    run_cycle(4'b1111, 8'h00, 16'hFFFF, "R7");
    run_cycle(4'b1111, 8'h00, 16'hFFFF, "R7");
    run_cycle(4'b0000, 8'h00, 16'hFFFF, "R2");
    // R1: spare code 2'b11 on port 2 loses to video on port 3
    run_cycle(4'b1100, 8'b0111_0000, 16'hFFFF, "R1");
    run_cycle(4'b0000, 8'h00, 16'hFFFF, "R1");
    // R1: spare code competes as best effort with code 2'b00
    run_cycle(4'b0011, 8'b0000_0011, 16'hFFFF, "R1");
    run_cycle(4'b0011, 8'b0000_0011, 16'hFFFF, "R1");
    run_cycle(4'b0000, 8'h00, 16'hFFFF, "R4");
    // R4: video on port 0 with limit 3 starved by low latency on port 1
    for (int k = 0; k < 4; k++)
      run_cycle(4'b0011, 8'b0000_1001, 16'hFFF3, "R4");
    run_cycle(4'b0000, 8'h00, 16'hFFFF, "R8");
    // R8: zero limit on port 2 beats low latency on port 0 at once
    run_cycle(4'b0101, 8'b0001_0010, 16'hF0FF, "R8");
    run_cycle(4'b0000, 8'h00, 16'hFFFF, "R6");
    // R6: two expired video requests with equal age, lowest index wins
    run_cycle(4'b1010, 8'b0100_0100, 16'h0000, "R6");
    run_cycle(4'b1010, 8'b0100_0100, 16'h0000, "R6");

    // Exhaustive sweep of valid masks and class tags with large limits
    for (int v = 0; v < 16; v++)
      for (int c = 0; c < 256; c++)
        run_cycle(4'(v), 8'(c), 16'hFFFF, "");

    // Held pseudo-random patterns with small limits
    lfsr = 16'hACE1;
    pv = '0; pc = '0; pl = '0;
    for (int n = 0; n < 3000; n++) begin
      if (n % 5 == 0) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pv = lfsr[3:0] | lfsr[7:4];
        pc = lfsr[15:8];
      end
      if (n % 200 == 0)
        pl = {2'b00, lfsr[1:0], 2'b00, lfsr[3:2], 2'b00, lfsr[5:4], 2'b00, lfsr[7:6]};
      run_cycle(pv, pc, pl, "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule